// File: doc/BRIEF.md
# Filtered External Interrupt with Pulse-Width Timer

This block conditions one external interrupt pin. It synchronises the pin and can invert it, so that either level can count as active. It then passes the result through a sampling noise filter that runs on a slow tick. The filtered level moves only after several consecutive equal samples, so glitches and short pulses never reach the interrupt logic. A selectable edge of the filtered level sets a sticky interrupt request. Software clears the request with a one-cycle acknowledge.

The filtered level can also gate an internal 8-bit width timer. While the gate is open, the timer counts sample ticks. When the gate closes, the count is latched as the measured pulse width and a ready flag is raised. The count stops at its maximum value. With the default divider of 1000 and a 75 kHz clock, a sample is taken about every 13.3 ms. Three equal samples are needed, so a pulse of 40 ms or more is always accepted.

Top module: `ext_irq_filter`

## Requirements
- R1: After reset, irq_req, filt_level and width_ready are 0 and width_val is 0, whatever the pin level.
- R2: A pin pulse shorter than 2*SAMPLE_DIV clocks never changes filt_level. A pulse of at least (CONFIRM+1)*SAMPLE_DIV clocks always does.
- R3: filt_level changes only in the cycle after a sample tick, and only after CONFIRM (default 3) consecutive samples that all differ from its current value.
- R4: With cfg_pol_low=1 a low pin is the active level. With cfg_pol_low=0 a high pin is the active level.
- R5: cfg_edge_fall=0 sets the request on an inactive-to-active change of filt_level. cfg_edge_fall=1 sets it on an active-to-inactive change.
- R6: irq_req is never set while cfg_irq_en is 0, and an edge seen while it is disabled is not kept for later.
- R7: irq_req stays set until irq_ack is high for one cycle. An edge in the same cycle as irq_ack leaves irq_req set.
- R8: While cfg_gate_en=1 and filt_level is active, the timer counts sample ticks. When the gate closes, width_val takes the count and width_ready goes to 1. A pin pulse lasting exactly k*SAMPLE_DIV clocks measures k.
- R9: The width count saturates at 255.
- R10: With cfg_gate_en=0, no measurement takes place, and width_val and width_ready keep their values.
- R11: width_ready returns to 0 when a new gated pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin | input | 1 | Raw external interrupt pin (asynchronous) |
| cfg_pol_low | input | 1 | 1: a low pin is the active level |
| cfg_edge_fall | input | 1 | 1: trigger on the falling edge of the filtered level |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_gate_en | input | 1 | Use the filtered level as the width-timer gate |
| irq_ack | input | 1 | One-cycle clear of the interrupt request |
| irq_req | output | 1 | Sticky interrupt request |
| filt_level | output | 1 | Filtered level, 1 = active |
| width_val | output | 8 | Last measured width in sample ticks |
| width_ready | output | 1 | A width measurement has completed |

## Verification
A corrupted sample history or tick counter shows up as a wrong filt_level. The error is visible within a few sample periods, either as a glitch that was let through or as a long pulse that was missed. A wrong request flag appears at irq_req within one clock of the edge or acknowledge that disturbed it. A wrong width count is only visible when the gate closes, when width_val and width_ready update. Width tests therefore use pulses that are exact multiples of the sample period, so the expected count is a single value.

// File: rtl/eirq_pkg.sv
// Shared definitions for the filtered external interrupt block.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package eirq_pkg;

    // Edge used to raise the interrupt request
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_t;

    // Highest count a WIDTH-bit saturating counter may hold
    function automatic int unsigned sat_max(input int unsigned bits);
        return (1 << bits) - 1;
    endfunction

endpackage

// File: rtl/eirq_tick_gen.sv
// Divides the system clock to a one-cycle sample tick every DIV clocks.
// Assumes: DIV >= 1. The tick is high on the last cycle of each period.
module eirq_tick_gen #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    // Free-running period counter
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            // R3: ticks are isolated single cycles when the divider exceeds 1
            a_r3_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/eirq_filter.sv
// Synchronises the pin, applies polarity and filters it by sampling on the tick.
// The output level moves only once CONFIRM consecutive samples agree.
// Assumes: CONFIRM >= 2, tick is a single-cycle strobe.
module eirq_filter #(
    parameter int unsigned CONFIRM = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol_low,
    input  logic tick,
    output logic level
);
    logic [1:0]         sync_q;
    logic               cond;
    logic [CONFIRM-1:0] hist;
    logic [CONFIRM-1:0] hist_nx;

    // Two-flop synchroniser for the asynchronous pin
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], pin};
    end

    assign cond    = sync_q[1] ^ pol_low;
    assign hist_nx = {hist[CONFIRM-2:0], cond};

    // Sample history and the debounced level, both advanced on the tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist  <= '0;
            level <= 1'b0;
        end else if (tick) begin
            hist <= hist_nx;
            if (&hist_nx)       level <= 1'b1;
            else if (~|hist_nx) level <= 1'b0;
        end
    end

    // R3: level moves only right after a tick
    a_r3_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> $past(tick));
    // R3: a rise is backed by a full history of active samples
    a_r3_rise_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level) |-> (&hist));
    // R3: a fall is backed by a full history of inactive samples
    a_r3_fall_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level) |-> (~|hist));

endmodule

// File: rtl/eirq_width_timer.sv
// Counts sample ticks while the gate is open and latches the count when it closes.
// Assumes: gate changes only synchronously and tick is a single-cycle strobe.
module eirq_width_timer #(
    parameter int unsigned BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate,
    input  logic            tick,
    output logic [BITS-1:0] width,
    output logic            ready
);
    import eirq_pkg::*;
    localparam logic [BITS-1:0] MAXV = BITS'(sat_max(BITS));

    logic [BITS-1:0] cnt;
    logic            gate_q;
    logic            g_rise;
    logic            g_fall;

    assign g_rise = gate & ~gate_q;
    assign g_fall = ~gate & gate_q;

    // Gate history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate;
    end

    // Saturating tick counter, restarted when the gate opens
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt <= '0;
        else if (g_rise)                      cnt <= '0;
        else if (gate && tick && cnt != MAXV) cnt <= cnt + 1'b1;
    end

    // Result and ready flag, updated at the gate edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width <= '0;
            ready <= 1'b0;
        end else if (g_fall) begin
            width <= cnt;
            ready <= 1'b1;
        end else if (g_rise) begin
            ready <= 1'b0;
        end
    end

    // R9: a full counter stays full
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !g_rise) |=> (cnt == MAXV));
    // R8: the result moves only when the gate has just closed
    a_r8_latch_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        (width != $past(width)) |-> $past(g_fall));
    // R11: a new gated pulse clears ready
    a_r11_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
        g_rise |=> !ready);

endmodule

// File: rtl/ext_irq_filter.sv
// Top level: filtered external interrupt with a gated pulse-width timer.
// Assumes: cfg_* inputs are quasi-static, and irq_ack is a one-cycle pulse.
module ext_irq_filter #(
    parameter int unsigned SAMPLE_DIV = 1000,
    parameter int unsigned CONFIRM    = 3,
    parameter int unsigned WIDTH_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pin,
    input  logic                  cfg_pol_low,
    input  logic                  cfg_edge_fall,
    input  logic                  cfg_irq_en,
    input  logic                  cfg_gate_en,
    input  logic                  irq_ack,
    output logic                  irq_req,
    output logic                  filt_level,
    output logic [WIDTH_BITS-1:0] width_val,
    output logic                  width_ready
);
    import eirq_pkg::*;

    logic      tick;
    logic      lvl_q;
    logic      edge_hit;
    edge_sel_t esel;

    eirq_tick_gen #(.DIV(SAMPLE_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    eirq_filter #(.CONFIRM(CONFIRM)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (pin),
        .pol_low (cfg_pol_low),
        .tick    (tick),
        .level   (filt_level)
    );

    eirq_width_timer #(.BITS(WIDTH_BITS)) u_width (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (cfg_gate_en & filt_level),
        .tick  (tick),
        .width (width_val),
        .ready (width_ready)
    );

    assign esel = edge_sel_t'(cfg_edge_fall);

    // Previous filtered level, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= filt_level;
    end

    assign edge_hit = (esel == EDGE_FALL) ? (lvl_q & ~filt_level)
                                          : (filt_level & ~lvl_q);

    // Sticky request: an enabled edge wins over the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)                       irq_req <= 1'b0;
        else if (cfg_irq_en && edge_hit)  irq_req <= 1'b1;
        else if (irq_ack)                 irq_req <= 1'b0;
    end

    // R6: the request only rises while enabled
    a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(cfg_irq_en));
    // R7: an acknowledge without an edge clears the request
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !edge_hit) |=> !irq_req);
    // R7: an enabled edge always leaves the request set
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_en && edge_hit) |=> irq_req);
    // R5: the request only rises after the filtered level has moved
    a_r5_edge_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (lvl_q != $past(lvl_q)));

endmodule

// File: tb/ext_irq_filter_test.sv
module ext_irq_filter_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic       cfg_pol_low = 1'b0;
    logic       cfg_edge_fall = 1'b0;
    logic       cfg_irq_en = 1'b0;
    logic       cfg_gate_en = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic       filt_level;
    logic [7:0] width_val;
    logic       width_ready;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ext_irq_filter #(.SAMPLE_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .pin(pin), .cfg_pol_low(cfg_pol_low),
        .cfg_edge_fall(cfg_edge_fall), .cfg_irq_en(cfg_irq_en),
        .cfg_gate_en(cfg_gate_en), .irq_ack(irq_ack), .irq_req(irq_req),
        .filt_level(filt_level), .width_val(width_val), .width_ready(width_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic v, input int len);
        pin = v;
        cyc(len);
        pin = ~v;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        cyc(1);
        irq_ack = 1'b0;
        cyc(1);
    endtask

    task automatic t_reset();
        check(irq_req == 0,     "R1 irq_req",     irq_req, 0);
        check(filt_level == 0,  "R1 filt_level",  filt_level, 0);
        check(width_ready == 0, "R1 width_ready", width_ready, 0);
        check(width_val == 0,   "R1 width_val",   width_val, 0);
    endtask

    task automatic t_reject();
        bit seen = 0;
        cfg_irq_en = 1;
        pin = 1;
        for (int i = 0; i < 2*DIV-1; i++) begin cyc(1); if (filt_level) seen = 1; end
        pin = 0;
        for (int i = 0; i < 40; i++) begin cyc(1); if (filt_level) seen = 1; end
        check(!seen,        "R2 short pulse rejected", seen, 0);
        check(irq_req == 0, "R2 no irq from glitch",   irq_req, 0);
    endtask

    task automatic t_accept_rise();
        pin = 1; cyc(40);
        check(filt_level == 1, "R2 long pulse accepted", filt_level, 1);
        check(irq_req == 1,    "R5 rising edge irq",     irq_req, 1);
        ack();
        check(irq_req == 0,    "R7 ack clears",          irq_req, 0);
        pin = 0; cyc(40);
        check(filt_level == 0, "R3 level returns",       filt_level, 0);
        check(irq_req == 0,    "R5 no irq on fall in rise mode", irq_req, 0);
    endtask

    task automatic t_fall_mode();
        cfg_edge_fall = 1;
        pin = 1; cyc(40);
        check(irq_req == 0, "R5 no irq on rise in fall mode", irq_req, 0);
        pin = 0; cyc(40);
        check(irq_req == 1, "R5 falling edge irq", irq_req, 1);
        ack();
        check(irq_req == 0, "R7 ack clears fall irq", irq_req, 0);
        cfg_edge_fall = 0;
    endtask

    task automatic t_disabled();
        cfg_irq_en = 0;
        pin = 1; cyc(40);
        check(filt_level == 1, "R6 filter still runs", filt_level, 1);
        check(irq_req == 0,    "R6 disabled no irq",   irq_req, 0);
        cfg_irq_en = 1; cyc(10);
        check(irq_req == 0,    "R6 edge not kept",     irq_req, 0);
        pin = 0; cyc(40);
    endtask

    task automatic t_polarity();
        cfg_pol_low = 1; pin = 0; cyc(40);
        check(filt_level == 1, "R4 low pin active",   filt_level, 1);
        check(irq_req == 1,    "R4 irq on low level", irq_req, 1);
        ack();
        pin = 1; cyc(40);
        check(filt_level == 0, "R4 high pin inactive", filt_level, 0);
        cfg_pol_low = 0; pin = 0; cyc(40);
        check(filt_level == 0, "R4 restored polarity", filt_level, 0);
        check(irq_req == 0,    "R4 no spurious irq",   irq_req, 0);
    endtask

    task automatic t_ack_race();
        int guard = 0;
        pin = 1; cyc(40); pin = 0; cyc(40);
        check(irq_req == 1, "R7 sticky while unacked", irq_req, 1);
        pin = 1;
        while (!filt_level && guard < 100) begin cyc(1); guard++; end
        irq_ack = 1; cyc(1); irq_ack = 0;
        check(irq_req == 1, "R7 edge beats ack", irq_req, 1);
        cyc(1); ack();
        check(irq_req == 0, "R7 later ack clears", irq_req, 0);
        cyc(30); pin = 0; cyc(40);
    endtask

    task automatic t_width();
        cfg_irq_en = 0; cfg_gate_en = 1;
        pulse(1, 10*DIV); cyc(40);
        check(width_ready == 1, "R8 ready after pulse", width_ready, 1);
        check(width_val == 10,  "R8 width of 10 ticks", width_val, 10);
        pulse(1, 5*DIV);
        check(width_ready == 0, "R11 ready cleared by new pulse", width_ready, 0);
        cyc(40);
        check(width_val == 5,   "R8 width of 5 ticks", width_val, 5);
    endtask

    task automatic t_sat();
        pulse(1, 275*DIV); cyc(40);
        check(width_val == 255, "R9 saturates", width_val, 255);
    endtask

    task automatic t_gate_off();
        cfg_gate_en = 0;
        pulse(1, 8*DIV); cyc(40);
        check(width_val == 255, "R10 value kept", width_val, 255);
        check(width_ready == 1, "R10 ready kept", width_ready, 1);
    endtask

    initial begin
        cyc(3);
        pin = 1; cyc(2);
        t_reset();
        pin = 0;
        rst_n = 1; cyc(2);
        t_reset();
        t_reject();
        t_accept_rise();
        t_fall_mode();
        t_disabled();
        t_polarity();
        t_ack_race();
        t_width();
        t_sat();
        t_gate_off();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule